// File: doc/BRIEF.md
# Two-Frame SPI Byte Access Master

This block is an SPI bus master that lets on-chip logic read or write a single byte of a remote 32-location, 8-bit wide memory. The user side raises a one-cycle start strobe together with a write flag, a 5-bit address and, for writes, a data byte. The block then runs the access on the serial lines and reports the end with a one-cycle done pulse. For reads, the byte it fetched appears on a parallel output.

Every access takes two chip-select frames of eight SCLK cycles each, with chip select released between them. The first frame carries a command byte that holds the direction flag and the address. The second frame carries the data byte. On a write the master drives that byte on MOSI. On a read the master samples it from MISO. SCLK idles low. MOSI only changes while SCLK is low, so the slave can sample on each rising edge. The SCLK half-period is a parameter counted in system clocks.

Top module: `spi_split_mem_master`

## Requirements
- R1: While the active-high synchronous reset is applied and afterwards until a start, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, busy is 0 and done is 0.
- R2: Each access begins with a chip-select frame of exactly 8 rising SCLK edges. On those edges MOSI carries the command byte MSB first: bit 7 is the direction flag, bits 6 and 5 are 0, and bits 4..0 are the address.
- R3: SCLK is 0 whenever spi_cs_n is 1. MOSI never changes while SCLK is high, nor on the cycle SCLK rises.
- R4: Each access uses exactly two frames. spi_cs_n stays 1 for at least 2 system clocks between the frames, and again before the next access can begin.
- R5: When the direction flag is 1 (write), the second frame carries wdata on MOSI, MSB first, over 8 rising edges.
- R6: When the direction flag is 0 (read), MOSI is 0 throughout the second frame. MISO is sampled on its 8 rising edges, and the first sample becomes rd_data bit 7.
- R7: busy is 1 from the cycle after an accepted start until done. done is a single-cycle pulse that coincides with busy returning to 0.
- R8: A start that arrives while busy is 1 is ignored. Changes to wr_en, addr or wdata after an accepted start do not affect the access in progress.
- R9: rd_data changes only when a read completes. It keeps its value while idle and through write accesses.
- R10: Every SCLK high phase and low phase inside a frame lasts HALF_DIV system clocks. The lead time from chip-select assertion to the first rising edge also lasts HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an access |
| wr_en | input | 1 | 1 = write, 0 = read, sampled with start |
| addr | input | 5 | Memory location, sampled with start |
| wdata | input | 8 | Byte to write, sampled with start |
| rd_data | output | 8 | Byte returned by the last read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The hardest case to reach from the ports is a start strobe, with different inputs, that arrives in the middle of an access. The block must neither open a third frame nor let the new inputs leak into the data frame. The stimulus raises such a strobe about twenty clocks into the command frame, with the direction, address and data all inverted. It also alters the inputs right after a normal start. A slave model built into the bench holds its own memory and counts chip-select falls. A frame it was not told to expect, or a byte that differs from the expected one, therefore shows up as a mismatch.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LOC_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP1,
    ST_DATA,
    ST_GAP2
  } seq_state_t;

  // direction flag on top, zero padding, location in the low bits
  function automatic logic [BYTE_W-1:0] cmd_byte(input logic wr, input logic [LOC_W-1:0] loc);
    return {wr, {(BYTE_W-LOC_W-1){1'b0}}, loc};
  endfunction
endpackage

// File: rtl/spim_halfdiv.sv
module spim_halfdiv #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spim_frame.sv
module spim_frame #(
  parameter int unsigned HALF = 4,
  parameter int unsigned W    = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] tx,
  input  logic         miso,
  output logic         sclk,
  output logic         cs_n,
  output logic         mosi,
  output logic [W-1:0] rx,
  output logic         rise_evt,
  output logic         fall_evt,
  output logic         done
);
  localparam int unsigned PH_LAST = 2 * W;
  localparam int unsigned PW      = $clog2(PH_LAST + 1);

  logic          active;
  logic [PW-1:0] ph;
  logic          sclk_q;
  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;
  logic          done_q;
  logic          tick;
  logic          end_evt;

  spim_halfdiv #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (go && !active),
    .en   (active),
    .tick (tick)
  );

  // even phases are SCLK-low halves, odd ones high halves, last is the tail
  assign end_evt  = tick && (ph == PW'(PH_LAST));
  assign rise_evt = tick && !ph[0] && !end_evt;
  assign fall_evt = tick && ph[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ph     <= '0;
      sclk_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= end_evt;
      if (go && !active) begin
        active <= 1'b1;
        ph     <= '0;
        sclk_q <= 1'b0;
        tx_sh  <= tx;
      end else if (tick) begin
        if (end_evt) active <= 1'b0;
        else         ph     <= ph + 1'b1;
        if (rise_evt) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[W-2:0], miso};
        end
        if (fall_evt) begin
          sclk_q <= 1'b0;
          tx_sh  <= {tx_sh[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign cs_n = !active;
  assign mosi = active && tx_sh[W-1];
  assign rx   = rx_sh;
  assign done = done_q;
endmodule

// File: rtl/spi_split_mem_master.sv
module spi_split_mem_master
  import spim_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  seq_state_t        st;
  logic [GW-1:0]     gap_cnt;
  logic              go_q;
  logic [BYTE_W-1:0] tx_q;
  logic              wr_q;
  logic [BYTE_W-1:0] wd_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              done_q;

  // named internal events, used by the bound checker
  wire               frame_done;
  wire               sclk_rise;
  wire               sclk_fall;
  wire [BYTE_W-1:0]  frame_rx;
  wire               gap_end = (gap_cnt == GW'(GAP_CYC - 1));

  spim_frame #(.HALF(HALF_DIV), .W(BYTE_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .go       (go_q),
    .tx       (tx_q),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .rx       (frame_rx),
    .rise_evt (sclk_rise),
    .fall_evt (sclk_fall),
    .done     (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      gap_cnt <= '0;
      go_q    <= 1'b0;
      tx_q    <= '0;
      wr_q    <= 1'b0;
      wd_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          wr_q <= wr_en;
          wd_q <= wdata;
          tx_q <= cmd_byte(wr_en, addr);
          go_q <= 1'b1;
          st   <= ST_CMD;
        end
        ST_CMD: if (frame_done) begin
          gap_cnt <= '0;
          st      <= ST_GAP1;
        end
        ST_GAP1: if (gap_end) begin
          tx_q <= wr_q ? wd_q : '0;
          go_q <= 1'b1;
          st   <= ST_DATA;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        ST_DATA: if (frame_done) begin
          if (!wr_q) rdata_q <= frame_rx;
          gap_cnt <= '0;
          st      <= ST_GAP2;
        end
        ST_GAP2: if (gap_end) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign rd_data = rdata_q;
endmodule

// File: rtl/spim_checks.sv
module spim_checks (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi,
  input logic [7:0] rd_data,
  input logic       rise_evt,
  input logic       frame_done
);
  logic       cs_d;
  logic [4:0] rise_cnt;
  logic [1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d     <= 1'b1;
      rise_cnt <= '0;
      hi_cnt   <= '0;
    end else begin
      cs_d <= cs_n;
      if (cs_d && !cs_n)  rise_cnt <= '0;
      else if (rise_evt)  rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n)               hi_cnt <= '0;
      else if (hi_cnt != 2'd3) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_eight_edges_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !cs_d) |-> (rise_cnt == 5'd8));
  assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
  assert_cs_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs_d) |-> (hi_cnt >= 2'd2));
  assert_idle_cs_high_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  assert_frame_end_cs_R4: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> cs_n);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rd_data));
endmodule

bind spi_split_mem_master spim_checks u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .sclk       (spi_sclk),
  .cs_n       (spi_cs_n),
  .mosi       (spi_mosi),
  .rd_data    (rd_data),
  .rise_evt   (sclk_rise),
  .frame_done (frame_done)
);

// File: tb/spi_split_mem_master_tb.sv
module spi_split_mem_master_tb;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       miso = 1'b0;
  wire  [7:0] rd_data;
  wire        busy, done, sclk, cs_n, mosi;

  always #10 clk = ~clk;

  spi_split_mem_master #(.HALF_DIV(HALF), .GAP_CYC(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .busy(busy), .done(done),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_acc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] shadow[32];
  logic [7:0] slave_mem[32];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // slave model and monitor, evaluated away from the active edge
  logic       prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [7:0] s_sh = '0, s_out = '0;
  int         s_bits = 0, cs_falls = 0, lo_len = 0, hi_len = 0;
  int         bad_half = 0, gap_len = 0, min_gap = 1000;
  bit         s_is_data = 1'b0, s_wr = 1'b0;
  logic [4:0] s_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        cs_falls++;
        s_is_data = (cs_falls % 2) == 0;
        s_bits = 0;
        lo_len = 1;
        if (gap_len < min_gap) min_gap = gap_len;
        if (s_is_data && !s_wr) s_out = slave_mem[s_addr];
        else                    s_out = 8'h00;
        miso = s_out[7];
      end else if (!cs_n) begin
        if (sclk && !prev_sclk) begin
          if (lo_len != HALF) bad_half++;
          hi_len = 1;
          s_sh = {s_sh[6:0], mosi};
          s_bits++;
        end else if (!sclk && prev_sclk) begin
          if (hi_len != HALF) bad_half++;
          lo_len = 1;
          s_out = {s_out[6:0], 1'b0};
          miso = s_out[7];
        end else if (sclk) hi_len++;
        else lo_len++;
      end
      if (!prev_cs && cs_n) begin
        gap_len = 1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected frame", s_sh, 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(s_sh == e, t, "frame byte", s_sh, e);
          check(s_bits == 8, "R2", "rising edges in frame", s_bits, 8);
        end
        if (!s_is_data) begin
          s_wr = s_sh[7];
          s_addr = s_sh[4:0];
        end else if (s_wr) begin
          slave_mem[s_addr] = s_sh;
        end
      end else if (cs_n) begin
        gap_len++;
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
    end
  end

  task automatic access(input bit w, input logic [4:0] a, input logic [7:0] d, input bit poke);
    exp_q.push_back(8'((w ? 8'h80 : 8'h00) | {3'b000, a})); tag_q.push_back("R2");
    exp_q.push_back(w ? d : 8'h00); tag_q.push_back(w ? "R5" : "R6");
    n_acc++;
    @(negedge clk);
    start = 1'b1; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
    // R8: inputs disturbed after acceptance
    wr_en = ~w; addr = a + 5'd1; wdata = ~d;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; addr = ~a;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R7", "busy at done", busy, 0);
    if (w) shadow[a] = d;
    else check(rd_data == shadow[a], "R6", "read data", rd_data, shadow[a]);
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 32; i++) begin
      shadow[i] = 8'(i * 29 + 3);
      slave_mem[i] = 8'(i * 29 + 3);
    end
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(mosi == 1'b0, "R1", "mosi after reset", mosi, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);

    access(1'b1, 5'd0,  8'hA5, 1'b0);
    access(1'b1, 5'd31, 8'h3C, 1'b0);
    access(1'b0, 5'd31, 8'h00, 1'b0);
    access(1'b0, 5'd0,  8'h00, 1'b0);
    access(1'b0, 5'd7,  8'h00, 1'b0);
    access(1'b1, 5'd7,  8'hFF, 1'b1);
    access(1'b0, 5'd7,  8'h00, 1'b1);
    held = rd_data;
    access(1'b1, 5'd12, 8'h81, 1'b0);
    check(rd_data == held, "R9", "rd_data after write", rd_data, held);
    repeat (30) @(negedge clk);
    check(rd_data == held, "R9", "rd_data while idle", rd_data, held);
    access(1'b0, 5'd12, 8'h00, 1'b0);
    access(1'b1, 5'd21, 8'h00, 1'b0);
    access(1'b0, 5'd21, 8'h00, 1'b0);
    repeat (10) @(negedge clk);

    check(bad_half == 0, "R10", "half-period violations", bad_half, 0);
    check(min_gap >= 2, "R4", "minimum cs_n high run", min_gap, 2);
    check(cs_falls == 2 * n_acc, "R8", "frames issued", cs_falls, 2 * n_acc);
    check(exp_q.size() == 0, "R4", "frames missing", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule